// File: doc/BRIEF.md
# NAND Step Hamming Parity Generator

This block sits beside the byte path of a NAND flash controller. It builds a single-error-correcting Hamming code over every 256 bytes that pass while generation is enabled. It tracks the byte's position in the step and folds each byte into a set of line-parity and column-parity bits. When the last byte of a step arrives, the parity is turned into its stored 24-bit form and latched in an output register. A one-cycle strobe marks the capture. The three stored bytes are then played out on a byte port, most significant first, so that the controller can write them into the spare area.

A decode path compares the latched code with a code fetched back from flash. It is the XOR of the two. It classifies the difference as clean, a correctable single data-bit error (with the byte index and the bit index within that byte), a flipped bit in the stored code itself, or damage that cannot be corrected. Page sequencing, spare-area placement and any bus transfers are left to the surrounding controller.

Top module: `nand_hecc_gen`

## Requirements
- R1: After reset, eccCode is 0, and stepDone and spareValid are low.
- R2: A byte counts only in a cycle where eccEn and byteValid are both high. On the clock edge that takes the 256th counted byte of a step, the code is captured. stepDone is high for exactly the one following cycle.
- R3: The captured code has bits [1:0] = 2'b11. For every raw parity bit r, the code holds its inverse at bit r+2. Line parity covers each byte-address bit k (0..7): bit 8+2k is the inverted XOR of the data bits of all bytes whose address bit k is 0, and bit 9+2k does the same for bytes whose address bit k is 1. Column parity covers bit-index weight j (0..2): bit 2+2j is the inverted XOR of the data bits at positions whose index bit j is 0, taken over all bytes, and bit 3+2j does the same for positions whose index bit j is 1.
- R4: A byte presented while eccEn is low changes neither the parity nor the byte count.
- R5: A cycle with eccClr high zeroes the parity, the byte count and eccCode, and cancels any spare-byte output in progress. It takes precedence over a byte presented in the same cycle.
- R6: eccCode keeps its value until the next capture or clear.
- R7: spareValid is high for three cycles starting with the stepDone cycle. spareByte gives code bits [23:16], then [15:8], then [7:0].
- R8: chkStatus is 0 (clean) when refCode equals eccCode.
- R9: If every bit pair {2+2i, 3+2i} of the syndrome (eccCode XOR refCode) holds exactly one set bit, chkStatus is 1. errByte[k] is then syndrome bit 9+2k and errBit[j] is syndrome bit 3+2j, which together locate the flipped data bit.
- R10: A syndrome with exactly one bit set gives chkStatus 2 (error in the stored code).
- R11: Any other non-zero syndrome gives chkStatus 3 (uncorrectable).
- R12: Steps sent back to back are independent: each captured code depends only on the bytes of its own step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eccEn | input | 1 | Enables parity accumulation |
| eccClr | input | 1 | Synchronous clear of the parity state and the latched code |
| byteValid | input | 1 | byteData holds a byte this cycle |
| byteData | input | 8 | Data byte on the flash path |
| refCode | input | 24 | Code read back from flash, for the decode path |
| eccCode | output | 24 | Latched stored-form code of the last step |
| stepDone | output | 1 | One-cycle strobe after a capture |
| spareValid | output | 1 | spareByte holds a code byte |
| spareByte | output | 8 | Code bytes, most significant first |
| chkStatus | output | 2 | 0 clean, 1 correctable, 2 code error, 3 uncorrectable |
| errByte | output | 8 | Byte index of a correctable error, 0 otherwise |
| errBit | output | 3 | Bit index of a correctable error, 0 otherwise |

## Verification
A corrupted byte counter shows up as a stepDone pulse in the wrong cycle. That is visible at most 256 counted bytes later, and it also changes every following code. A wrong parity bit shows in eccCode and on the spare bytes in the cycle after capture. An error in the spare shift register shows within the three emission cycles. The bench compares every output on every clock against a behavioural model that computes codes straight from the bit definitions. The decode path is driven with codes taken from data containing deliberately flipped bits, so a wrong line or column mapping appears as a wrong errByte or errBit.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic accum;      // fold the current byte into the parity
    logic capture;    // last byte of a step: latch the stored code
    logic clear;      // zero all parity state
    logic spareShift; // advance the spare byte shifter
  } hecc_strobe_t;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_FIXABLE  = 2'd1,
    ST_CODE_ERR = 2'd2,
    ST_BROKEN   = 2'd3
  } hecc_status_e;

  // Mask of bit positions whose index has bit j set
  function automatic logic [7:0] colMask(input int j);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = ((i >> j) & 1) == 1;
    return m;
  endfunction

endpackage

// File: rtl/hecc_ctrl.sv
module hecc_ctrl
  import hecc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SPARE_N = 3,
  localparam int REM_W  = $clog2(SPARE_N + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eccEn,
  input  logic              eccClr,
  input  logic              byteValid,
  output hecc_strobe_t      strobe,
  output logic [ADDR_W-1:0] byteAddr,
  output logic              stepDone,
  output logic              spareValid
);

  logic [ADDR_W-1:0] addrQ;
  logic [REM_W-1:0]  remQ;
  logic              lastByte;

  assign lastByte = &addrQ;

  always_comb begin
    strobe.clear      = eccClr;
    strobe.accum      = eccEn && byteValid && !eccClr;
    strobe.capture    = strobe.accum && lastByte;
    strobe.spareShift = (remQ != '0) && !eccClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      remQ     <= '0;
      stepDone <= 1'b0;
    end else if (strobe.clear) begin
      addrQ    <= '0;
      remQ     <= '0;
      stepDone <= 1'b0;
    end else begin
      stepDone <= strobe.capture;
      if (strobe.accum) addrQ <= addrQ + 1'b1;
      if (strobe.capture) remQ <= REM_W'(SPARE_N);
      else if (remQ != '0) remQ <= remQ - 1'b1;
    end
  end

  assign byteAddr   = addrQ;
  assign spareValid = (remQ != '0);

endmodule

// File: rtl/hecc_datapath.sv
module hecc_datapath
  import hecc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  localparam int RAW_W   = 2 * ADDR_W + 6,
  localparam int CODE_W  = RAW_W + 2,
  localparam int SPARE_N = (CODE_W + 7) / 8,
  localparam int SPARE_W = SPARE_N * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  hecc_strobe_t      strobe,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [7:0]        byteData,
  output logic [CODE_W-1:0] eccCode,
  output logic [7:0]        spareByte
);

  logic [RAW_W-1:0]   accQ;
  logic [RAW_W-1:0]   contrib;
  logic [RAW_W-1:0]   accNext;
  logic [CODE_W-1:0]  storedNext;
  logic [SPARE_W-1:0] spareQ;
  logic               bytePar;

  assign bytePar = ^byteData;

  // Column parity: even/odd pair per bit-index weight
  for (genvar j = 0; j < 3; j++) begin : g_col
    localparam logic [7:0] MASK = colMask(j);
    assign contrib[2*j]   = ^(byteData & ~MASK);
    assign contrib[2*j+1] = ^(byteData & MASK);
  end

  // Line parity: even/odd pair per byte-address bit
  for (genvar k = 0; k < ADDR_W; k++) begin : g_line
    assign contrib[6+2*k] = bytePar & ~byteAddr[k];
    assign contrib[7+2*k] = bytePar & byteAddr[k];
  end

  assign accNext    = accQ ^ contrib;
  assign storedNext = ~{accNext, 2'b00};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ    <= '0;
      eccCode <= '0;
      spareQ  <= '0;
    end else if (strobe.clear) begin
      accQ    <= '0;
      eccCode <= '0;
      spareQ  <= '0;
    end else if (strobe.capture) begin
      accQ    <= '0;
      eccCode <= storedNext;
      spareQ  <= SPARE_W'(storedNext) << (SPARE_W - CODE_W);
    end else begin
      if (strobe.accum)      accQ   <= accNext;
      if (strobe.spareShift) spareQ <= spareQ << 8;
    end
  end

  assign spareByte = spareQ[SPARE_W-1 -: 8];

endmodule

// File: rtl/hecc_syndrome.sv
module hecc_syndrome
  import hecc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  localparam int CODE_W = 2 * ADDR_W + 8,
  localparam int NPAIR  = ADDR_W + 3,
  localparam int ONES_W = $clog2(CODE_W + 1)
) (
  input  logic [CODE_W-1:0] eccCode,
  input  logic [CODE_W-1:0] refCode,
  output hecc_status_e      status,
  output logic [ADDR_W-1:0] errByte,
  output logic [2:0]        errBit
);

  logic [CODE_W-1:0] syn;
  logic [ONES_W-1:0] ones;
  logic              pairsOk;
  logic              fixable;

  assign syn = eccCode ^ refCode;

  always_comb begin
    ones    = '0;
    pairsOk = 1'b1;
    for (int i = 0; i < CODE_W; i++) ones = ones + ONES_W'(syn[i]);
    for (int p = 0; p < NPAIR; p++) pairsOk = pairsOk & (syn[2+2*p] ^ syn[3+2*p]);
  end

  always_comb begin
    if (syn == '0)                  status = ST_CLEAN;
    else if (pairsOk)               status = ST_FIXABLE;
    else if (ones == ONES_W'(1))    status = ST_CODE_ERR;
    else                            status = ST_BROKEN;
  end

  assign fixable = (syn != '0) && pairsOk;

  for (genvar k = 0; k < ADDR_W; k++) begin : g_byte
    assign errByte[k] = fixable & syn[9+2*k];
  end
  for (genvar j = 0; j < 3; j++) begin : g_bit
    assign errBit[j] = fixable & syn[3+2*j];
  end

endmodule

// File: rtl/nand_hecc_gen.sv
module nand_hecc_gen
  import hecc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  localparam int CODE_W = 2 * ADDR_W + 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eccEn,
  input  logic              eccClr,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic [CODE_W-1:0] refCode,
  output logic [CODE_W-1:0] eccCode,
  output logic              stepDone,
  output logic              spareValid,
  output logic [7:0]        spareByte,
  output logic [1:0]        chkStatus,
  output logic [ADDR_W-1:0] errByte,
  output logic [2:0]        errBit
);

  localparam int SPARE_N = (CODE_W + 7) / 8;

  hecc_strobe_t      strobe;
  logic [ADDR_W-1:0] byteAddr;
  hecc_status_e      status;

  hecc_ctrl #(.ADDR_W(ADDR_W), .SPARE_N(SPARE_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .eccEn(eccEn), .eccClr(eccClr),
    .byteValid(byteValid), .strobe(strobe), .byteAddr(byteAddr),
    .stepDone(stepDone), .spareValid(spareValid)
  );

  hecc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteAddr(byteAddr),
    .byteData(byteData), .eccCode(eccCode), .spareByte(spareByte)
  );

  hecc_syndrome #(.ADDR_W(ADDR_W)) u_syn (
    .eccCode(eccCode), .refCode(refCode), .status(status),
    .errByte(errByte), .errBit(errBit)
  );

  assign chkStatus = status;

endmodule

// File: rtl/hecc_checker.sv
module hecc_checker #(
  parameter int ADDR_W  = 8,
  localparam int CODE_W = 2 * ADDR_W + 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              eccClr,
  input logic [CODE_W-1:0] refCode,
  input logic [CODE_W-1:0] eccCode,
  input logic              stepDone,
  input logic              spareValid,
  input logic [7:0]        spareByte,
  input logic [1:0]        chkStatus
);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    stepDone |=> !stepDone);

  assert_code_tail_R3: assert property (@(posedge clk) disable iff (!rstN)
    stepDone |-> eccCode[1:0] == 2'b11);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(eccClr) |-> (eccCode == '0 && !spareValid && !stepDone));

  assert_code_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!stepDone && !$past(eccClr)) |-> $stable(eccCode));

  assert_spare_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    stepDone |-> (spareValid && spareByte == eccCode[CODE_W-1 -: 8]));

  assert_match_clean_R8: assert property (@(posedge clk) disable iff (!rstN)
    (refCode == eccCode) |-> chkStatus == 2'd0);

  assert_single_code_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(eccCode ^ refCode) == 1) |-> chkStatus == 2'd2);

endmodule

bind nand_hecc_gen hecc_checker #(.ADDR_W(ADDR_W)) u_hecc_checker (
  .clk(clk), .rstN(rstN), .eccClr(eccClr), .refCode(refCode),
  .eccCode(eccCode), .stepDone(stepDone), .spareValid(spareValid),
  .spareByte(spareByte), .chkStatus(chkStatus)
);

// File: tb/nand_hecc_gen_bench.sv
`timescale 1ns/1ps
module nand_hecc_gen_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        eccEn = 1'b0, eccClr = 1'b0, byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic [23:0] refCode = '0;
  logic [23:0] eccCode;
  logic        stepDone, spareValid;
  logic [7:0]  spareByte, errByte;
  logic [1:0]  chkStatus;
  logic [2:0]  errBit;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nand_hecc_gen u_nand_hecc_gen (
    .clk(clk), .rstN(rstN), .eccEn(eccEn), .eccClr(eccClr),
    .byteValid(byteValid), .byteData(byteData), .refCode(refCode),
    .eccCode(eccCode), .stepDone(stepDone), .spareValid(spareValid),
    .spareByte(spareByte), .chkStatus(chkStatus), .errByte(errByte),
    .errBit(errBit)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Code straight from the bit definitions of R3
  function automatic logic [23:0] refCalc(input logic [7:0] d [256]);
    bit le[8], lo[8], ce[3], co[3];
    logic [23:0] c;
    for (int k = 0; k < 8; k++) begin le[k] = 0; lo[k] = 0; end
    for (int j = 0; j < 3; j++) begin ce[j] = 0; co[j] = 0; end
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 8; b++) begin
        for (int k = 0; k < 8; k++)
          if ((a >> k) & 1) lo[k] ^= d[a][b]; else le[k] ^= d[a][b];
        for (int j = 0; j < 3; j++)
          if ((b >> j) & 1) co[j] ^= d[a][b]; else ce[j] ^= d[a][b];
      end
    c = 24'h3;
    for (int k = 0; k < 8; k++) begin c[8+2*k] = ~le[k]; c[9+2*k] = ~lo[k]; end
    for (int j = 0; j < 3; j++) begin c[2+2*j] = ~ce[j]; c[3+2*j] = ~co[j]; end
    return c;
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    if (seed == 3) return 8'hFF;
    return 8'((i * seed * 37 + seed * 11) ^ (i >> 3));
  endfunction

  // Behavioural reference model
  logic [7:0]  mBuf [256];
  int          mCnt = 0, mSpLeft = 0;
  logic [23:0] mCode = '0, mSpSh = '0;
  bit          mDone = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mSpLeft = 0; mCode = '0; mSpSh = '0; mDone = 0;
    end else begin
      mDone = 0;
      if (mSpLeft > 0) begin mSpSh = mSpSh << 8; mSpLeft--; end
      if (eccClr) begin
        mCnt = 0; mCode = '0; mSpLeft = 0; mSpSh = '0;
      end else if (eccEn && byteValid) begin
        mBuf[mCnt] = byteData;
        mCnt++;
        if (mCnt == 256) begin
          mCode = refCalc(mBuf); mCnt = 0; mDone = 1;
          mSpLeft = 3; mSpSh = mCode;
        end
      end
    end
  end

  logic [23:0] capQ[$];
  logic [7:0]  spQ[$];

  always @(posedge clk) begin
    #1;
    if (rstN && !finished) begin
      check(eccCode == mCode, "R3 eccCode vs model", eccCode, mCode);
      check(stepDone == mDone, "R2 stepDone vs model", stepDone, mDone);
      check(spareValid == (mSpLeft > 0), "R7 spareValid vs model", spareValid, mSpLeft > 0);
      if (mSpLeft > 0)
        check(spareByte == mSpSh[23:16], "R7 spareByte vs model", spareByte, mSpSh[23:16]);
      if (stepDone) capQ.push_back(eccCode);
      if (spareValid) spQ.push_back(spareByte);
    end
  end

  task automatic putByte(input logic en, input logic vld, input logic [7:0] b);
    @(negedge clk);
    eccEn = en; byteValid = vld; byteData = b;
  endtask

  logic [7:0] sent [256];

  task automatic sendStep(input int seed, input bit mixed);
    for (int i = 0; i < 256; i++) begin
      if (mixed && (i % 7 == 3)) begin
        putByte(1'b1, 1'b0, 8'hA5);
        putByte(1'b0, 1'b1, ~pat(seed, i));
      end
      putByte(1'b1, 1'b1, pat(seed, i));
      sent[i] = pat(seed, i);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) putByte(1'b1, 1'b0, 8'h00);
  endtask

  function automatic logic [23:0] flipCode(input logic [7:0] d [256],
      input int a1, input int b1, input int a2, input int b2);
    logic [7:0] t [256];
    t = d;
    t[a1][b1] = ~t[a1][b1];
    if (a2 >= 0) t[a2][b2] = ~t[a2][b2];
    return refCalc(t);
  endfunction

  task automatic chkDec(input logic [23:0] r, input logic [1:0] st,
      input logic [7:0] eb, input logic [2:0] bi, input string tag);
    @(negedge clk);
    refCode = r;
    #1;
    check(chkStatus == st, {tag, " status"}, chkStatus, st);
    check(errByte == eb, {tag, " errByte"}, errByte, eb);
    check(errBit == bi, {tag, " errBit"}, errBit, bi);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [7:0]  stepA [256];
    logic [7:0]  stepB [256];
    logic [7:0]  stepC [256];
    logic [23:0] codeA, held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(eccCode == 24'h0, "R1 eccCode after reset", eccCode, 0);
    check(!stepDone && !spareValid, "R1 strobes after reset", {stepDone, spareValid}, 0);

    // R2 R3 first step, plain stream
    sendStep(1, 1'b0);
    stepA = sent;
    idle(6);
    codeA = refCalc(stepA);
    check(eccCode == codeA, "R3 step code", eccCode, codeA);
    check(capQ.size() == 1, "R2 one strobe per step", capQ.size(), 1);
    check(spQ.size() == 3, "R7 three spare bytes", spQ.size(), 3);
    if (spQ.size() == 3)
      check({spQ[0], spQ[1], spQ[2]} == codeA, "R7 spare byte order",
            {spQ[0], spQ[1], spQ[2]}, codeA);

    // R8..R11 decode path
    chkDec(codeA, 2'd0, 8'h00, 3'd0, "R8 equal codes");
    chkDec(flipCode(stepA, 8'h5A, 6, -1, 0), 2'd1, 8'h5A, 3'd6, "R9 byte 5A bit 6");
    chkDec(flipCode(stepA, 0, 0, -1, 0), 2'd1, 8'h00, 3'd0, "R9 byte 0 bit 0");
    chkDec(flipCode(stepA, 255, 7, -1, 0), 2'd1, 8'hFF, 3'd7, "R9 byte FF bit 7");
    chkDec(codeA ^ 24'h000400, 2'd2, 8'h00, 3'd0, "R10 code bit 10");
    chkDec(codeA ^ 24'h000001, 2'd2, 8'h00, 3'd0, "R10 code bit 0");
    chkDec(flipCode(stepA, 3, 1, 200, 5), 2'd3, 8'h00, 3'd0, "R11 two data bits");
    chkDec(codeA ^ 24'h800003, 2'd3, 8'h00, 3'd0, "R11 three code bits");

    // R6 code holds through a partial step
    held = eccCode;
    for (int i = 0; i < 100; i++) putByte(1'b1, 1'b1, 8'(i));
    idle(2);
    check(eccCode == held, "R6 code held mid-step", eccCode, held);

    // R5 clear with a byte in the same cycle
    @(negedge clk);
    eccClr = 1'b1; byteValid = 1'b1; byteData = 8'h3C;
    @(negedge clk);
    eccClr = 1'b0; byteValid = 1'b0;
    check(eccCode == 24'h0, "R5 code cleared", eccCode, 0);

    // R4 disabled bytes and gaps interleaved
    sendStep(2, 1'b1);
    stepB = sent;
    idle(2);
    check(eccCode == refCalc(stepB), "R4 disabled bytes ignored", eccCode, refCalc(stepB));

    // R5 clear during spare emission
    sendStep(5, 1'b0);
    @(negedge clk);
    eccEn = 1'b1; byteValid = 1'b0; eccClr = 1'b1;
    @(negedge clk);
    eccClr = 1'b0;
    check(!spareValid && eccCode == 24'h0, "R5 emission cancelled", {spareValid, eccCode}, 0);

    // R12 back-to-back steps
    capQ.delete();
    sendStep(3, 1'b0);
    stepC = sent;
    sendStep(4, 1'b0);
    idle(4);
    check(capQ.size() == 2, "R12 two captures", capQ.size(), 2);
    if (capQ.size() == 2) begin
      check(capQ[0] == refCalc(stepC), "R12 first code", capQ[0], refCalc(stepC));
      check(capQ[1] == refCalc(sent), "R12 second code", capQ[1], refCalc(sent));
    end
    finish();
  end

endmodule